// File: doc/BRIEF.md
# Modified-Line Directory for a Host-Cached Device Window

This block sits inside an IO device whose local memory is visible to a host through two aliases: a cached read alias and a write-combining write alias. The host keeps lines of the read alias in its cache, and the device has no way to invalidate those copies. The host manages coherence in software instead. The block watches every write that lands in the tracked window, whether it comes from the device's own logic or from the host through the write alias. For each 64-byte line that one of these writes touches, it sets a bit in a 512-bit directory.

At the end of a phase, the host fetches the whole directory as one 64-byte line through the read port. It then flushes only the lines whose bits are set. Lines with a clear bit stay valid in its cache. A phase-clear command then empties the directory for the next phase.

A read returns a consistent snapshot of the directory. Writes that arrive after the snapshot is taken stay recorded for the next read. A write whose address falls outside the window records no line bit. Instead it raises a sticky out-of-range flag.

Top module: `mlt_tracker`

## Requirements
- R1: A write's byte address maps to line index addr[14:6], which is the address divided by 64. Any write that lands anywhere inside a line sets directory bit number equal to that index. No other bit changes.
- R2: A write with at least one strobe bit set counts as a modification, whatever its size. A write whose strobe is all zero has no effect: it sets no bit and does not raise the out-of-range flag.
- R3: The device port and the host port may both carry a write in the same cycle. Both lines are recorded, whether they are the same line or different lines.
- R4: Only addresses below 0x8000 (512 lines) are tracked. A counted write with any of addr[19:15] set records no bit and sets oor_flag at the next edge.
- R5: oor_flag stays set until a phase clear.
- R6: A phase_clr pulse zeroes every directory bit and oor_flag at the next clock edge.
- R7: A write in the same cycle as phase_clr is recorded after the clear, so its bit, or oor_flag, is set after that edge.
- R8: A write accepted in cycle t is visible to a read requested in cycle t+1 or later.
- R9: A rd_req in cycle t gives rd_valid high for exactly cycle t+1. In that cycle rd_bitmap bit i is the directory state for line i as it stood at the start of cycle t. That state excludes writes made in cycle t, and it is the pre-clear contents if phase_clr is also high in cycle t. Reading never clears bits.
- R10: rd_bitmap holds its last snapshot in every cycle that follows a cycle without rd_req.
- R11: While rst is high, and after it is released, the directory is empty, oor_flag is low, rd_valid is low and rd_bitmap is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_wr_valid | input | 1 | Device-side write observed |
| dev_wr_addr | input | 20 | Byte address of device write, aligned to 8 bytes |
| dev_wr_strb | input | 8 | Byte strobes of device write |
| host_wr_valid | input | 1 | Host write through the write alias observed |
| host_wr_addr | input | 20 | Byte address of host write, aligned to 8 bytes |
| host_wr_strb | input | 8 | Byte strobes of host write |
| phase_clr | input | 1 | Phase boundary: empty the directory |
| rd_req | input | 1 | Host requests a directory snapshot |
| rd_valid | output | 1 | Snapshot on rd_bitmap is fresh this cycle |
| rd_bitmap | output | 512 | Packed directory, bit i for line i |
| oor_flag | output | 1 | Sticky: a counted write fell outside the window |

## Verification
Several properties are checked on every cycle: each decoder flags at most one line and never flags a line and out-of-range together, a directory bit drops only on a phase clear, a recorded write survives a simultaneous clear, the out-of-range flag is sticky, and the snapshot pulse and hold timing are respected. Some behaviour can only be shown by the bench scenarios, because it depends on the address arithmetic and on how events are ordered across cycles. This covers which exact line a given address lands on, the window edge at lines 511 and 512, zero-strobe writes, and collisions between the device and host ports. It also covers a read taken in the same cycle as a write or a clear, and a later read that recovers the bits the earlier snapshot missed. A behavioural reference model is compared against every output on every clock under both directed and random traffic.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    localparam int unsigned LINE_BYTES_DEF = 64;
    localparam int unsigned NUM_LINES_DEF  = 512;
    localparam int unsigned ADDR_W_DEF     = 20;
    localparam int unsigned STRB_W_DEF     = 8;

    // Write-observation sources; the order only selects array slots.
    typedef enum logic [0:0] {
        SRC_DEV  = 1'b0,
        SRC_HOST = 1'b1
    } wr_src_e;

    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/mlt_line_decode.sv
module mlt_line_decode #(
    parameter int unsigned ADDR_W     = mlt_pkg::ADDR_W_DEF,
    parameter int unsigned STRB_W     = mlt_pkg::STRB_W_DEF,
    parameter int unsigned LINE_BYTES = mlt_pkg::LINE_BYTES_DEF,
    parameter int unsigned NUM_LINES  = mlt_pkg::NUM_LINES_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [STRB_W-1:0]    wr_strb,
    output logic [NUM_LINES-1:0] set_o,
    output logic                 oor_o
);
    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W = $clog2(NUM_LINES);
    localparam int unsigned WIN_W = OFF_W + IDX_W;

    logic             counted;
    logic             in_win;
    logic             take;
    logic [IDX_W-1:0] idx;

    assign counted = wr_valid && (wr_strb != '0);
    assign in_win  = (wr_addr[ADDR_W-1:WIN_W] == '0);
    assign take    = counted && in_win;
    assign idx     = wr_addr[WIN_W-1:OFF_W];
    assign oor_o   = counted && !in_win;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign set_o[g] = take && (idx == IDX_W'(g));
    end

    // R1
    onehot_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_o));

    // R4
    win_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(oor_o && (set_o != '0)));

    // R2
    zero_strb_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strb == '0) |-> (set_o == '0 && !oor_o));

endmodule

// File: rtl/mlt_dir_store.sv
module mlt_dir_store #(
    parameter int unsigned NUM_LINES = mlt_pkg::NUM_LINES_DEF,
    parameter int unsigned NUM_SRC   = mlt_pkg::NUM_SRC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_SRC-1:0]   oor_evt_i,
    output logic [NUM_LINES-1:0] bits_q,
    output logic                 oor_q
);
    logic [NUM_LINES-1:0] bits_d;
    logic                 oor_d;

    // Clear first, then merge this cycle's writes on top.
    always_comb begin
        bits_d = (clr_i ? '0 : bits_q) | set_i;
        oor_d  = (oor_q && !clr_i) || (oor_evt_i != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            oor_q  <= 1'b0;
        end else begin
            bits_q <= bits_d;
            oor_q  <= oor_d;
        end
    end

    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0 && oor_evt_i == '0) |=> (bits_q == '0 && !oor_q));

    // R7
    set_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i)));

    // R9
    no_lost_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (&(bits_q | ~$past(bits_q))));

    // R5
    oor_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (oor_q && !clr_i) |=> oor_q);

endmodule

// File: rtl/mlt_snap_port.sv
module mlt_snap_port #(
    parameter int unsigned NUM_LINES = mlt_pkg::NUM_LINES_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_req_i,
    input  logic [NUM_LINES-1:0] bits_i,
    output logic                 rd_valid_o,
    output logic [NUM_LINES-1:0] rd_bitmap_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o  <= 1'b0;
            rd_bitmap_o <= '0;
        end else begin
            rd_valid_o <= rd_req_i;
            if (rd_req_i) begin
                rd_bitmap_o <= bits_i;
            end
        end
    end

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |=> $stable(rd_bitmap_o));

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> rd_valid_o);

    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |=> !rd_valid_o);

endmodule

// File: rtl/mlt_tracker.sv
module mlt_tracker #(
    parameter int unsigned ADDR_W     = mlt_pkg::ADDR_W_DEF,
    parameter int unsigned STRB_W     = mlt_pkg::STRB_W_DEF,
    parameter int unsigned LINE_BYTES = mlt_pkg::LINE_BYTES_DEF,
    parameter int unsigned NUM_LINES  = mlt_pkg::NUM_LINES_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dev_wr_valid,
    input  logic [ADDR_W-1:0]    dev_wr_addr,
    input  logic [STRB_W-1:0]    dev_wr_strb,
    input  logic                 host_wr_valid,
    input  logic [ADDR_W-1:0]    host_wr_addr,
    input  logic [STRB_W-1:0]    host_wr_strb,
    input  logic                 phase_clr,
    input  logic                 rd_req,
    output logic                 rd_valid,
    output logic [NUM_LINES-1:0] rd_bitmap,
    output logic                 oor_flag
);
    import mlt_pkg::*;

    logic [NUM_SRC-1:0]                 src_vld;
    logic [NUM_SRC-1:0][ADDR_W-1:0]     src_addr;
    logic [NUM_SRC-1:0][STRB_W-1:0]     src_strb;
    logic [NUM_SRC-1:0][NUM_LINES-1:0]  src_set;
    logic [NUM_SRC-1:0]                 src_oor;
    logic [NUM_LINES-1:0]               set_vec;
    logic [NUM_LINES-1:0]               bits_q;

    assign src_vld[SRC_DEV]   = dev_wr_valid;
    assign src_addr[SRC_DEV]  = dev_wr_addr;
    assign src_strb[SRC_DEV]  = dev_wr_strb;
    assign src_vld[SRC_HOST]  = host_wr_valid;
    assign src_addr[SRC_HOST] = host_wr_addr;
    assign src_strb[SRC_HOST] = host_wr_strb;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        mlt_line_decode #(
            .ADDR_W     (ADDR_W),
            .STRB_W     (STRB_W),
            .LINE_BYTES (LINE_BYTES),
            .NUM_LINES  (NUM_LINES)
        ) dec_i (
            .clk      (clk),
            .rst      (rst),
            .wr_valid (src_vld[s]),
            .wr_addr  (src_addr[s]),
            .wr_strb  (src_strb[s]),
            .set_o    (src_set[s]),
            .oor_o    (src_oor[s])
        );
    end

    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            set_vec = set_vec | src_set[s];
        end
    end

    mlt_dir_store #(
        .NUM_LINES (NUM_LINES),
        .NUM_SRC   (NUM_SRC)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (phase_clr),
        .set_i     (set_vec),
        .oor_evt_i (src_oor),
        .bits_q    (bits_q),
        .oor_q     (oor_flag)
    );

    mlt_snap_port #(
        .NUM_LINES (NUM_LINES)
    ) snap_i (
        .clk         (clk),
        .rst         (rst),
        .rd_req_i    (rd_req),
        .bits_i      (bits_q),
        .rd_valid_o  (rd_valid),
        .rd_bitmap_o (rd_bitmap)
    );

    // R9
    snap_match_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (rd_bitmap == $past(bits_q)));

    // R3
    dual_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_set[SRC_DEV] != '0 && src_set[SRC_HOST] != '0)
            |=> ((bits_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: tb/mlt_tracker_tb.sv
module mlt_tracker_tb_top;

    localparam int unsigned NL = 512;

    logic          clk = 1'b0;
    logic          rst;
    logic          dev_wr_valid, host_wr_valid;
    logic [19:0]   dev_wr_addr, host_wr_addr;
    logic [7:0]    dev_wr_strb, host_wr_strb;
    logic          phase_clr, rd_req;
    logic          rd_valid;
    logic [NL-1:0] rd_bitmap;
    logic          oor_flag;

    always #4 clk = ~clk;

    mlt_tracker dut_i (
        .clk           (clk),
        .rst           (rst),
        .dev_wr_valid  (dev_wr_valid),
        .dev_wr_addr   (dev_wr_addr),
        .dev_wr_strb   (dev_wr_strb),
        .host_wr_valid (host_wr_valid),
        .host_wr_addr  (host_wr_addr),
        .host_wr_strb  (host_wr_strb),
        .phase_clr     (phase_clr),
        .rd_req        (rd_req),
        .rd_valid      (rd_valid),
        .rd_bitmap     (rd_bitmap),
        .oor_flag      (oor_flag)
    );

    // Behavioural reference state
    bit [NL-1:0] mdl_bits;
    bit [NL-1:0] mdl_snap;
    bit          mdl_rdv;
    bit          mdl_oor;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [NL-1:0] act, input logic [NL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic void mdl_write(input bit v, input int unsigned a, input bit [7:0] s);
        if (v && s != 0) begin
            if (a < 32768) mdl_bits[a / 64] = 1'b1;
            else           mdl_oor = 1'b1;
        end
    endfunction

    // One cycle: drive, advance model, clock, then compare at the falling edge.
    task automatic step(input string req,
                        input bit dv, input int unsigned da, input bit [7:0] ds,
                        input bit hv, input int unsigned ha, input bit [7:0] hs,
                        input bit clr, input bit rd);
        dev_wr_valid  = dv;  dev_wr_addr  = da[19:0]; dev_wr_strb  = ds;
        host_wr_valid = hv;  host_wr_addr = ha[19:0]; host_wr_strb = hs;
        phase_clr     = clr; rd_req       = rd;
        mdl_rdv = rd;
        if (rd) mdl_snap = mdl_bits;
        if (clr) begin
            mdl_bits = '0;
            mdl_oor  = 1'b0;
        end
        mdl_write(dv, da, ds);
        mdl_write(hv, ha, hs);
        @(posedge clk);
        @(negedge clk);
        chk(req, "rd_valid", {{(NL-1){1'b0}}, rd_valid}, {{(NL-1){1'b0}}, mdl_rdv});
        chk(req, "oor_flag", {{(NL-1){1'b0}}, oor_flag}, {{(NL-1){1'b0}}, mdl_oor});
        chk(req, "rd_bitmap", rd_bitmap, mdl_snap);
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic dwr(input string req, input int unsigned a, input bit [7:0] s);
        step(req, 1, a, s, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(input string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic clr(input string req);
        step(req, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        rst = 1'b1;
        dev_wr_valid = 0; host_wr_valid = 0; phase_clr = 0; rd_req = 0;
        dev_wr_addr = 0; host_wr_addr = 0; dev_wr_strb = 0; host_wr_strb = 0;
        mdl_bits = '0; mdl_snap = '0; mdl_rdv = 0; mdl_oor = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs during reset
        chk("R11", "rd_valid", {{(NL-1){1'b0}}, rd_valid}, '0);
        chk("R11", "rd_bitmap", rd_bitmap, '0);
        rst = 1'b0;
        idle("R11");
        rd("R11");                       // empty directory after reset
        idle("R10");

        // R1: two addresses inside line 1, one inside line 300
        dwr("R1", 32'h40, 8'hFF);
        dwr("R1", 32'h78, 8'hFF);
        dwr("R1", 300 * 64 + 16, 8'h0F);
        rd("R1");
        idle("R10");
        idle("R10");

        // R2: single byte strobe counts; zero strobe is ignored everywhere
        dwr("R2", 5 * 64 + 8, 8'h01);
        dwr("R2", 6 * 64, 8'h00);
        dwr("R2", 32'hF0000, 8'h00);     // out of window but zero strobe
        rd("R2");

        // R3: both ports at once, different lines then the same line
        step("R3", 1, 10 * 64, 8'hFF, 1, 20 * 64 + 56, 8'h80, 0, 0);
        step("R3", 1, 30 * 64, 8'h01, 1, 30 * 64 + 8, 8'h02, 0, 0);
        rd("R3");

        // R4: window edge, last line vs first line past the window
        dwr("R4", 511 * 64 + 56, 8'hFF);
        dwr("R4", 32'h8000, 8'hFF);
        rd("R4");
        // R5: flag survives unrelated traffic and reads
        dwr("R5", 2 * 64, 8'hFF);
        rd("R5");
        idle("R5");

        // R6: clear empties directory and flag
        clr("R6");
        rd("R6");

        // R7: write and out-of-range write during a clear survive it
        step("R7", 1, 40 * 64, 8'h10, 1, 32'h9000, 8'h01, 1, 0);
        rd("R7");

        // R8 and R9: read in same cycle as a write misses it, next read sees it
        step("R9", 1, 41 * 64, 8'hFF, 0, 0, 0, 0, 1);
        rd("R8");
        // R9: read in same cycle as clear returns pre-clear contents
        step("R9", 0, 0, 0, 0, 0, 0, 1, 1);
        rd("R9");
        // R9: back-to-back reads do not clear
        dwr("R9", 7 * 64, 8'hFF);
        rd("R9");
        rd("R9");
        idle("R10");

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int unsigned da, ha;
            bit [7:0] ds, hs;
            da = ($urandom % 8 == 0) ? ($urandom & 32'hFFFF8) : ($urandom & 32'h7FF8);
            ha = ($urandom % 8 == 0) ? ($urandom & 32'hFFFF8) : ($urandom & 32'h7FF8);
            ds = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            hs = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            step("R3", $urandom % 2 == 0, da, ds, $urandom % 2 == 0, ha, hs,
                 $urandom % 97 == 0, $urandom % 5 == 0);
        end
        report();
    end

endmodule